// File: doc/BRIEF.md
# Three-Share Threshold 4-bit S-box

This block evaluates a fixed 4-bit bijective substitution on a value that exists only as three XOR shares. The caller never hands over the plain nibble: it supplies three nibbles whose XOR is the value, and it receives three nibbles whose XOR is the substituted value. The substitution is factored into two quadratic maps, G first and F second. Each map is computed as three share functions, and every output share reads only two of the three input shares. No single gate cone ever sees the whole secret.

A register separates the shared G results from the F layer. The recombined result is therefore valid one clock after the inputs are presented. Two optional reorder stages, one in front of each layer, swap the three shares independently for every bit position under caller-supplied random selects. They change which wire carries which share but never the recombined value. The selects come from an external random source.

Top module: `ts_sbox3`

## Requirements
- R1: In a cycle after an accepted input, out_a^out_b^out_c equals S(in_a^in_b^in_c), where S maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
- R2: S equals F(G(v)), where G maps 0..F to 7,E,9,2,B,0,4,D,5,C,A,1,8,3,6,F and F maps 0..F to 0,8,B,7,A,3,1,C,4,6,F,9,E,D,5,2.
- R3: With all selects zero and only in_a = v non-zero, the output shares are out_a = 0, out_b = S(v)^C and out_c = C. This fixes the placement of constant, linear and cross terms.
- R4: With all selects zero and only in_b = v non-zero, the output shares are out_a = 0, out_b = 0 and out_c = S(v).
- R5: out_valid is high in exactly the cycles that follow a cycle with in_valid high.
- R6: While in_valid is low the share register holds its contents. With sel_f unchanged, the output shares keep their previous values and out_valid is low.
- R7: The front reorder treats bit i under select sel_g[3i+2:3i]. Select values 0..7 send sources (A,B,C) = (in_a,in_b,in_c) to (first,second,third) as ABC, ACB, BAC, BCA, CAB, CBA, BCA, CAB.
- R8: Any value on sel_g or sel_f leaves the recombined output as stated in R1.
- R9: After reset, out_valid is low and all three output shares are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input shares are valid this cycle |
| in_a | input | 4 | Input share A |
| in_b | input | 4 | Input share B |
| in_c | input | 4 | Input share C |
| sel_g | input | 12 | Per-bit reorder selects ahead of the G layer |
| sel_f | input | 12 | Per-bit reorder selects ahead of the F layer |
| out_valid | output | 1 | Output shares hold a fresh result |
| out_a | output | 4 | Output share 1 |
| out_b | output | 4 | Output share 2 |
| out_c | output | 4 | Output share 3 |

## Verification
The bench builds two copies side by side: one with SHUFFLE_EN=1 and one with SHUFFLE_EN=0, and both are fed identical stimulus. With zero selects the two copies must agree share for share. The exact share patterns of R3 and R4 then expose any misplaced constant, linear or cross term. The reordering copy additionally reaches the select encodings. Each select is identified by where a lone non-zero share lands, and random selects show that recombination survives every reordering.

// File: rtl/ts_sbox3.sv
module ts_sbox3 #(
  parameter bit SHUFFLE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  in_a,
  input  logic [3:0]  in_b,
  input  logic [3:0]  in_c,
  input  logic [11:0] sel_g,
  input  logic [11:0] sel_f,
  output logic        out_valid,
  output logic [3:0]  out_a,
  output logic [3:0]  out_b,
  output logic [3:0]  out_c
);

  localparam logic [3:0] G_CONST = 4'h7;
  localparam logic [3:0] F_CONST = 4'h0;

  function automatic logic [11:0] reorder(input logic [3:0] a, b, c,
                                          input logic [11:0] s);
    logic [3:0] p, q, r;
    for (int i = 0; i < 4; i++) begin
      case (s[3*i +: 3])
        3'd0:    {p[i], q[i], r[i]} = {a[i], b[i], c[i]};
        3'd1:    {p[i], q[i], r[i]} = {a[i], c[i], b[i]};
        3'd2:    {p[i], q[i], r[i]} = {b[i], a[i], c[i]};
        3'd3:    {p[i], q[i], r[i]} = {b[i], c[i], a[i]};
        3'd4:    {p[i], q[i], r[i]} = {c[i], a[i], b[i]};
        3'd5:    {p[i], q[i], r[i]} = {c[i], b[i], a[i]};
        3'd6:    {p[i], q[i], r[i]} = {b[i], c[i], a[i]};
        default: {p[i], q[i], r[i]} = {c[i], a[i], b[i]};
      endcase
    end
    return {p, q, r};
  endfunction

  function automatic logic xq(input logic [3:0] m, o, input int i, j);
    return (m[i] & m[j]) ^ (m[i] & o[j]) ^ (o[i] & m[j]);
  endfunction

  // bit 3 = x, 2 = y, 1 = z, 0 = w; m carries own-index terms, o the partner
  function automatic logic [3:0] g_part(input logic [3:0] m, o);
    logic [3:0] r;
    r[3] = m[2] ^ m[1] ^ m[0];
    r[2] = m[2] ^ m[1];
    r[1] = m[3] ^ m[1] ^ xq(m, o, 2, 0) ^ xq(m, o, 1, 0);
    r[0] = m[0] ^ xq(m, o, 3, 2) ^ xq(m, o, 3, 1) ^ xq(m, o, 2, 1);
    return r;
  endfunction

  function automatic logic [3:0] f_part(input logic [3:0] m, o);
    logic [3:0] r;
    r[3] = m[2] ^ m[1] ^ m[0] ^ xq(m, o, 3, 0);
    r[2] = m[3] ^ xq(m, o, 1, 0);
    r[1] = m[2] ^ m[1] ^ xq(m, o, 3, 0);
    r[0] = m[1] ^ xq(m, o, 2, 0);
    return r;
  endfunction

  function automatic logic [3:0] sbox_ref(input logic [3:0] v);
    case (v)
      4'h0: return 4'hC;  4'h1: return 4'h5;  4'h2: return 4'h6;  4'h3: return 4'hB;
      4'h4: return 4'h9;  4'h5: return 4'h0;  4'h6: return 4'hA;  4'h7: return 4'hD;
      4'h8: return 4'h3;  4'h9: return 4'hE;  4'hA: return 4'hF;  4'hB: return 4'h8;
      4'hC: return 4'h4;  4'hD: return 4'h7;  4'hE: return 4'h1;  default: return 4'h2;
    endcase
  endfunction

  logic [3:0] x1, x2, x3;
  logic [3:0] y1_q, y2_q, y3_q;
  logic [3:0] y1, y2, y3;
  logic       vld_q;

  generate
    if (SHUFFLE_EN) begin : g_mix
      assign {x1, x2, x3} = reorder(in_a, in_b, in_c, sel_g);
      assign {y1, y2, y3} = reorder(y1_q, y2_q, y3_q, sel_f);
      always_comb assert_reorder_g_xor_R8: assert ((x1 ^ x2 ^ x3) == (in_a ^ in_b ^ in_c));
      always_comb assert_reorder_f_xor_R8: assert ((y1 ^ y2 ^ y3) == (y1_q ^ y2_q ^ y3_q));
    end else begin : g_plain
      assign {x1, x2, x3} = {in_a, in_b, in_c};
      assign {y1, y2, y3} = {y1_q, y2_q, y3_q};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      y1_q  <= '0;
      y2_q  <= '0;
      y3_q  <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        y1_q <= G_CONST ^ g_part(x2, x3);
        y2_q <= g_part(x3, x1);
        y3_q <= g_part(x1, x2);
      end
    end
  end

  assign out_valid = vld_q;
  assign out_a     = F_CONST ^ f_part(y2, y3);
  assign out_b     = f_part(y3, y1);
  assign out_c     = f_part(y1, y2);

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_recombine_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_a ^ out_b ^ out_c) == sbox_ref($past(in_a ^ in_b ^ in_c))));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $stable(sel_f)) |=> $stable({out_a, out_b, out_c}));

endmodule

// File: tb/ts_sbox3_test.sv
`timescale 1ns/1ps
module ts_sbox3_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_a = '0, in_b = '0, in_c = '0;
  logic [11:0] sel_g = '0, sel_f = '0;
  logic        ov, ov_p;
  logic [3:0]  oa, ob, oc, pa, pb, pc;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ts_sbox3 #(.SHUFFLE_EN(1'b1)) uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .sel_g(sel_g), .sel_f(sel_f),
    .out_valid(ov), .out_a(oa), .out_b(ob), .out_c(oc));
  ts_sbox3 #(.SHUFFLE_EN(1'b0)) uut_plain (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .sel_g(sel_g), .sel_f(sel_f),
    .out_valid(ov_p), .out_a(pa), .out_b(pb), .out_c(pc));

  function automatic logic [3:0] gmap(input logic [3:0] v);
    logic [63:0] t = 64'h7E92B04D5CA1836F;
    return t[63 - 4*v -: 4];
  endfunction
  function automatic logic [3:0] fmap(input logic [3:0] v);
    logic [63:0] t = 64'h08B7A31C46F9ED52;
    return t[63 - 4*v -: 4];
  endfunction
  function automatic logic [3:0] smap(input logic [3:0] v);
    logic [63:0] t = 64'hC56B90AD3EF84712;
    return t[63 - 4*v -: 4];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] a, b, c,
                       input logic [11:0] sg, sf);
    in_valid = v; in_a = a; in_b = b; in_c = c; sel_g = sg; sel_f = sf;
    @(posedge clk); #2;
  endtask

  // cycle-by-cycle reference model
  logic       m_vld = 1'b0;
  logic [3:0] m_val = '0;
  always @(posedge clk) begin
    if (!rst_n) m_vld <= 1'b0;
    else begin
      m_vld <= in_valid;
      if (in_valid) m_val <= smap(in_a ^ in_b ^ in_c);
    end
  end
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ov == m_vld && ov_p == m_vld, "R5 valid", {ov, ov_p}, {m_vld, m_vld});
      if (m_vld) begin
        chk((oa ^ ob ^ oc) == m_val, "R1/R8 recombine shuffled", oa ^ ob ^ oc, m_val);
        chk((pa ^ pb ^ pc) == m_val, "R1 recombine plain", pa ^ pb ^ pc, m_val);
      end
    end
  end

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] ra, rb, h1, h2, h3;
    int q0src[8] = '{0, 0, 1, 1, 2, 2, 1, 2};
    int q1src[8] = '{1, 2, 0, 2, 0, 1, 2, 0};
    repeat (3) @(posedge clk);
    #2;
    chk(ov == 1'b0 && {oa, ob, oc} == 12'h0, "R9 reset", {ov, oa, ob, oc}, 0);
    rst_n = 1'b1;

    // R2: composition against the plain table
    for (int v = 0; v < 16; v++)
      chk(fmap(gmap(v[3:0])) == smap(v[3:0]), "R2 F(G(v))", fmap(gmap(v[3:0])), smap(v[3:0]));

    // R1: all 16 values, several random share splits each
    for (int v = 0; v < 16; v++)
      for (int k = 0; k < 4; k++) begin
        ra = 4'($urandom); rb = 4'($urandom);
        drive(1'b1, ra, rb, v[3:0] ^ ra ^ rb, 12'($urandom), 12'($urandom));
      end

    // R3 / R4: exact share placement, selects zero
    for (int v = 1; v < 16; v++) begin
      drive(1'b1, v[3:0], 4'h0, 4'h0, 12'h0, 12'h0);
      chk({oa, ob, oc} == {4'h0, smap(v[3:0]) ^ 4'hC, 4'hC}, "R3 share A placement",
          {oa, ob, oc}, {4'h0, smap(v[3:0]) ^ 4'hC, 4'hC});
      chk({pa, pb, pc} == {oa, ob, oc}, "R3 plain matches", {pa, pb, pc}, {oa, ob, oc});
      drive(1'b1, 4'h0, v[3:0], 4'h0, 12'h0, 12'h0);
      chk({oa, ob, oc} == {8'h00, smap(v[3:0])}, "R4 share B placement",
          {oa, ob, oc}, {8'h00, smap(v[3:0])});
    end

    // R6: hold while in_valid low
    drive(1'b1, 4'h9, 4'h0, 4'h0, 12'h0, 12'h0);
    h1 = oa; h2 = ob; h3 = oc;
    drive(1'b0, 4'h3, 4'h6, 4'hA, 12'h0, 12'h0);
    chk({oa, ob, oc} == {h1, h2, h3} && !ov, "R6 hold", {ov, oa, ob, oc}, {1'b0, h1, h2, h3});
    drive(1'b0, 4'hF, 4'h1, 4'h2, 12'h0, 12'h0);
    chk({oa, ob, oc} == {h1, h2, h3} && !ov, "R6 hold 2", {ov, oa, ob, oc}, {1'b0, h1, h2, h3});

    // R7: select encodings, locate where a lone share lands
    for (int s = 0; s < 8; s++) begin
      logic [3:0] v = 4'(s + 3);
      logic [3:0] sh[3];
      sh = '{4'h0, 4'h0, 4'h0}; sh[q0src[s]] = v;
      drive(1'b1, sh[0], sh[1], sh[2], {4{s[2:0]}}, 12'h0);
      chk({oa, ob, oc} == {4'h0, smap(v) ^ 4'hC, 4'hC}, "R7 select first slot",
          {oa, ob, oc}, {4'h0, smap(v) ^ 4'hC, 4'hC});
      sh = '{4'h0, 4'h0, 4'h0}; sh[q1src[s]] = v;
      drive(1'b1, sh[0], sh[1], sh[2], {4{s[2:0]}}, 12'h0);
      chk({oa, ob, oc} == {8'h00, smap(v)}, "R7 select second slot",
          {oa, ob, oc}, {8'h00, smap(v)});
    end
    // R7: mixed selects per bit that all keep share A first
    drive(1'b1, 4'hB, 4'h0, 4'h0, {3'd1, 3'd0, 3'd1, 3'd0}, 12'h0);
    chk({oa, ob, oc} == {4'h0, smap(4'hB) ^ 4'hC, 4'hC}, "R7 per-bit selects",
        {oa, ob, oc}, {4'h0, smap(4'hB) ^ 4'hC, 4'hC});

    // R8: random output-side reorders on a held register
    drive(1'b1, 4'h4, 4'hD, 4'h2, 12'($urandom), 12'($urandom));
    for (int k = 0; k < 20; k++) begin
      drive(1'b0, 4'($urandom), 4'($urandom), 4'($urandom), 12'($urandom), 12'($urandom));
      chk((oa ^ ob ^ oc) == smap(4'h4 ^ 4'hD ^ 4'h2), "R8 sel_f reorder",
          oa ^ ob ^ oc, smap(4'h4 ^ 4'hD ^ 4'h2));
    end

    // R1 / R8: long random stream with idle gaps
    for (int k = 0; k < 400; k++)
      drive(1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
            12'($urandom), 12'($urandom));
    drive(1'b0, 4'h0, 4'h0, 4'h0, 12'h0, 12'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule